// File: doc/BRIEF.md
# Read/Write Request Arbiter with Write Drain

This block sits between the request side of a memory system and the command path of a single DRAM channel. It holds pending reads and pending writes in two separate queues and each cycle decides which request, if any, goes to the bank timing logic next. Reads get priority in normal operation. Each request covers one burst and takes one queue entry.

When enough writes pile up, the block enters a drain phase. It raises a flag that blocks any further read issue, waits a fixed number of cycles for the data bus to change direction, and then sends writes oldest first until the write queue is empty. A drain also starts when no reads are waiting and writes are pending. A new read whose address equals that of a queued write gets its data straight from the write queue on a response port, and never reaches the DRAM. A read sent to the DRAM keeps its read-queue slot until the external side reports its data has returned. The read picker can be set to strict arrival order, or to prefer the oldest read that targets a row already open in its bank.

Top module: `rwq_arbiter`

## Requirements
- R1: A read is accepted (`rd_ready` high) only while the queued reads plus the reads issued to DRAM whose `dram_rd_done` has not yet arrived number fewer than RQ_DEPTH. Each `dram_rd_done` pulse frees one such slot.
- R2: A write is accepted (`wr_ready` high) only while the write queue holds fewer than WQ_DEPTH entries.
- R3: A refused request (valid high, ready low at a clock edge) sets that side's retry flag (`rd_retry` or `wr_retry`) from the next cycle. The flag stays set until a request on that side is accepted, and clears in the cycle after that acceptance.
- R4: An accepted read whose address equals a queued write's address takes no read-queue entry and is never issued. In the following cycle `resp_valid` is high, `resp_addr` carries the read address and `resp_data` carries the data of the youngest matching write.
- R5: At reset the drain level is sampled as floor(WQ_DEPTH × `cfg_drain_pct` / 100). It is clamped to the range 1 to WQ_DEPTH. A drain starts when the write-queue count reaches this level.
- R6: `reads_blocked` rises in the cycle after a drain condition is seen. While it is high, no read is issued.
- R7: After `reads_blocked` rises, nothing is issued for exactly TURN_CYC cycles. After that, writes are issued oldest first (`iss_write` = 1).
- R8: The drain ends when the write queue is empty. `reads_blocked` falls in the next cycle, and read issue resumes.
- R9: If the read queue is empty while writes are pending, a drain starts even when the write count is below the drain level.
- R10: With `cfg_frfcfs` = 0, the read issued is the oldest one queued.
- R11: With `cfg_frfcfs` = 1, the read issued is the oldest queued read whose row equals the open row of its bank (`bank_open_vld` set). If no read hits an open row, the oldest read is issued. The address layout is {row[ROW_W], bank[BANK_W], column[COL_W]}, with the column in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; drain level sampled while low |
| cfg_drain_pct | input | PCT_W | Drain level as a percentage of write-queue capacity |
| cfg_frfcfs | input | 1 | 1 = prefer open-row reads, 0 = arrival order |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | ADDR_W | Read address |
| rd_retry | output | 1 | A read was refused and has not been followed by an accepted read |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be accepted |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_retry | output | 1 | A write was refused and has not been followed by an accepted write |
| iss_valid | output | 1 | A request is offered to the bank timing logic |
| iss_ready | input | 1 | Bank timing logic takes the offered request |
| iss_write | output | 1 | Offered request is a write |
| iss_addr | output | ADDR_W | Offered request address |
| iss_data | output | DATA_W | Offered write data (zero for reads) |
| bank_open_row | input | NBANK×ROW_W | Open row of each bank |
| bank_open_vld | input | NBANK | Bank has an open row |
| dram_rd_done | input | 1 | One issued read has returned its data |
| reads_blocked | output | 1 | Drain in progress, reads held back |
| resp_valid | output | 1 | Forwarded read response present (one cycle) |
| resp_addr | output | ADDR_W | Forwarded read address |
| resp_data | output | DATA_W | Forwarded read data |

## Verification
The assertions assume that `dram_rd_done` pulses only for reads the block has actually issued. They also assume `cfg_drain_pct` is steady for the whole reset window. The outstanding-slot bound is only meaningful if the external side never reports more returns than there were issues. The stimulus pulses `dram_rd_done` only after a read handshake has been observed, and sets the percentage before reset is asserted. Requests are driven on the falling edge and held for exactly one rising edge. So every acceptance, refusal or forwarding decision happens at a single known edge.

// File: rtl/rwq_pkg.sv
package rwq_pkg;

  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_TURN  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // Write count at which a drain is forced: floor(depth*pct/100), kept in [1, depth].
  function automatic int drain_level(input int depth, input int pct);
    int lvl;
    lvl = (depth * pct) / 100;
    if (lvl < 1) lvl = 1;
    if (lvl > depth) lvl = depth;
    return lvl;
  endfunction

endpackage

// File: rtl/rwq_shift_queue.sv
module rwq_shift_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [W-1:0]              push_data,
  input  logic                      pop,
  input  logic [IDX_W-1:0]          pop_idx,
  output logic [DEPTH-1:0][W-1:0]   ent,
  output logic [CNT_W-1:0]          count
);

  logic [DEPTH-1:0][W-1:0] mem;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        wr_pos;

  // Slot 0 is always the oldest entry; removal closes the gap.
  assign wr_pos = cnt_q - (pop ? CNT_W'(1) : CNT_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mem   <= '0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (i >= int'(pop_idx)) mem[i] <= mem[i+1];
        end
      end
      if (push) mem[IDX_W'(wr_pos)] <= push_data;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign ent   = mem;
  assign count = cnt_q;

endmodule

// File: rtl/rwq_read_picker.sv
module rwq_read_picker #(
  parameter int RQ_DEPTH = 4,
  parameter int ROW_W    = 6,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 4,
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W,
  localparam int NBANK   = 1 << BANK_W,
  localparam int IDX_W   = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1,
  localparam int CNT_W   = $clog2(RQ_DEPTH + 1)
) (
  input  logic [RQ_DEPTH-1:0][ADDR_W-1:0] ent,
  input  logic [CNT_W-1:0]                count,
  input  logic [NBANK-1:0][ROW_W-1:0]     open_row,
  input  logic [NBANK-1:0]                open_vld,
  input  logic                            frfcfs,
  output logic [IDX_W-1:0]                pick_idx
);

  function automatic logic row_open(input logic [ADDR_W-1:0] a,
                                    input logic [NBANK-1:0][ROW_W-1:0] rows,
                                    input logic [NBANK-1:0] vld);
    logic [BANK_W-1:0] b;
    b = a[COL_W +: BANK_W];
    return vld[b] && (rows[b] == a[COL_W+BANK_W +: ROW_W]);
  endfunction

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;

  // Scan youngest to oldest so the oldest hit is the last one kept.
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = RQ_DEPTH - 1; i >= 0; i--) begin
      if (i < int'(count) && row_open(ent[i], open_row, open_vld)) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign pick_idx = (frfcfs && hit_any) ? hit_idx : '0;

endmodule

// File: rtl/rwq_fwd_match.sv
module rwq_fwd_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int EW    = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][EW-1:0] ent,
  input  logic [CNT_W-1:0]         count,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     hit,
  output logic [DATA_W-1:0]        data
);

  // Oldest to youngest: the youngest matching write overrides earlier ones.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(count) && ent[i][DATA_W +: ADDR_W] == addr) begin
        hit  = 1'b1;
        data = ent[i][DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rwq_arbiter.sv
module rwq_arbiter
  import rwq_pkg::*;
#(
  parameter int ROW_W    = 6,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 4,
  parameter int DATA_W   = 16,
  parameter int RQ_DEPTH = 4,
  parameter int WQ_DEPTH = 4,
  parameter int TURN_CYC = 3,
  parameter int PCT_W    = 7,
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W,
  localparam int NBANK   = 1 << BANK_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PCT_W-1:0]             cfg_drain_pct,
  input  logic                         cfg_frfcfs,
  input  logic                         rd_valid,
  output logic                         rd_ready,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic                         rd_retry,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         wr_retry,
  output logic                         iss_valid,
  input  logic                         iss_ready,
  output logic                         iss_write,
  output logic [ADDR_W-1:0]            iss_addr,
  output logic [DATA_W-1:0]            iss_data,
  input  logic [NBANK-1:0][ROW_W-1:0]  bank_open_row,
  input  logic [NBANK-1:0]             bank_open_vld,
  input  logic                         dram_rd_done,
  output logic                         reads_blocked,
  output logic                         resp_valid,
  output logic [ADDR_W-1:0]            resp_addr,
  output logic [DATA_W-1:0]            resp_data
);

  localparam int RIDX_W = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1;
  localparam int WIDX_W = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1;
  localparam int RCNT_W = $clog2(RQ_DEPTH + 1);
  localparam int WCNT_W = $clog2(WQ_DEPTH + 1);
  localparam int WE_W   = ADDR_W + DATA_W;
  localparam int TC_W   = $clog2(TURN_CYC + 1);

  // Queue state
  logic [RQ_DEPTH-1:0][ADDR_W-1:0] rq_ent;
  logic [WQ_DEPTH-1:0][WE_W-1:0]   wq_ent;
  logic [RCNT_W-1:0]               rq_count;
  logic [WCNT_W-1:0]               wq_count;
  logic [RCNT_W-1:0]               rd_out;
  logic [WCNT_W-1:0]               drain_lvl;
  logic [RIDX_W-1:0]               pick_idx;
  logic                            fwd_hit;
  logic [DATA_W-1:0]               fwd_data;
  phase_e                          phase;
  logic [TC_W-1:0]                 turn_cnt;

  // Named internal events
  logic rd_acc, wr_acc, rq_push, rq_pop, wq_pop, rd_ret;
  logic rd_sel, wr_sel, drain_go, turn_done, drain_done;

  assign rd_ready = (int'(rq_count) + int'(rd_out)) < RQ_DEPTH;
  assign wr_ready = int'(wq_count) < WQ_DEPTH;
  assign rd_acc   = rd_valid && rd_ready;
  assign wr_acc   = wr_valid && wr_ready;
  assign rq_push  = rd_acc && !fwd_hit;

  assign rd_sel   = (phase == PH_READ) && (rq_count != '0);
  assign wr_sel   = (phase == PH_DRAIN) && (wq_count != '0);
  assign rq_pop   = rd_sel && iss_ready;
  assign wq_pop   = wr_sel && iss_ready;
  assign rd_ret   = dram_rd_done && ((rd_out != '0) || rq_pop);

  assign drain_go   = (phase == PH_READ) &&
                      ((wq_count >= drain_lvl) || (rq_count == '0 && wq_count != '0));
  assign turn_done  = (phase == PH_TURN) && (turn_cnt == TC_W'(TURN_CYC - 1));
  assign drain_done = (phase == PH_DRAIN) && (wq_count == '0);

  rwq_shift_queue #(.DEPTH(RQ_DEPTH), .W(ADDR_W)) rq_i (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .push_data(rd_addr),
    .pop(rq_pop), .pop_idx(pick_idx), .ent(rq_ent), .count(rq_count)
  );

  rwq_shift_queue #(.DEPTH(WQ_DEPTH), .W(WE_W)) wq_i (
    .clk(clk), .rst_n(rst_n), .push(wr_acc), .push_data({wr_addr, wr_data}),
    .pop(wq_pop), .pop_idx('0), .ent(wq_ent), .count(wq_count)
  );

  rwq_read_picker #(.RQ_DEPTH(RQ_DEPTH), .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) pick_i (
    .ent(rq_ent), .count(rq_count), .open_row(bank_open_row), .open_vld(bank_open_vld),
    .frfcfs(cfg_frfcfs), .pick_idx(pick_idx)
  );

  rwq_fwd_match #(.DEPTH(WQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fwd_i (
    .ent(wq_ent), .count(wq_count), .addr(rd_addr), .hit(fwd_hit), .data(fwd_data)
  );

  assign iss_valid     = rd_sel || wr_sel;
  assign iss_write     = wr_sel;
  assign iss_addr      = wr_sel ? wq_ent[0][DATA_W +: ADDR_W] : rq_ent[pick_idx];
  assign iss_data      = wr_sel ? wq_ent[0][DATA_W-1:0] : '0;
  assign reads_blocked = (phase != PH_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_READ;
      turn_cnt   <= '0;
      rd_out     <= '0;
      rd_retry   <= 1'b0;
      wr_retry   <= 1'b0;
      resp_valid <= 1'b0;
      resp_addr  <= '0;
      resp_data  <= '0;
      drain_lvl  <= WCNT_W'(drain_level(WQ_DEPTH, int'(cfg_drain_pct)));
    end else begin
      rd_out <= rd_out + RCNT_W'(rq_pop) - RCNT_W'(rd_ret);

      if (rd_valid) rd_retry <= !rd_ready;
      if (wr_valid) wr_retry <= !wr_ready;

      resp_valid <= rd_acc && fwd_hit;
      if (rd_acc && fwd_hit) begin
        resp_addr <= rd_addr;
        resp_data <= fwd_data;
      end

      unique case (phase)
        PH_READ: if (drain_go) begin
          phase    <= PH_TURN;
          turn_cnt <= '0;
        end
        PH_TURN: begin
          turn_cnt <= turn_cnt + TC_W'(1);
          if (turn_done) phase <= PH_DRAIN;
        end
        PH_DRAIN: if (drain_done) phase <= PH_READ;
        default:  phase <= PH_READ;
      endcase
    end
  end

endmodule

// File: rtl/rwq_arbiter_chk.sv
module rwq_arbiter_chk #(
  parameter int RQ_DEPTH = 4,
  parameter int WQ_DEPTH = 4,
  localparam int RCNT_W  = $clog2(RQ_DEPTH + 1),
  localparam int WCNT_W  = $clog2(WQ_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              iss_valid,
  input logic              iss_write,
  input logic              reads_blocked,
  input logic              resp_valid,
  input logic [RCNT_W-1:0] rq_count,
  input logic [WCNT_W-1:0] wq_count,
  input logic [RCNT_W-1:0] rd_out,
  input logic              drain_go
);

  assert_rd_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rq_count) + int'(rd_out)) <= RQ_DEPTH);

  assert_wq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wq_count) <= WQ_DEPTH);

  assert_fwd_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(rd_valid && rd_ready));

  assert_block_after_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reads_blocked && drain_go) |=> reads_blocked);

  assert_no_read_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reads_blocked |-> !(iss_valid && !iss_write));

  assert_quiet_on_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reads_blocked) |-> !iss_valid);

  assert_write_in_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_write) |-> reads_blocked);

  assert_drain_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reads_blocked && wq_count == '0) |=> !reads_blocked);

endmodule

bind rwq_arbiter rwq_arbiter_chk #(.RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .iss_valid(iss_valid), .iss_write(iss_write), .reads_blocked(reads_blocked),
  .resp_valid(resp_valid), .rq_count(rq_count), .wq_count(wq_count),
  .rd_out(rd_out), .drain_go(drain_go)
);

// File: tb/rwq_arbiter_tb_top.sv
`timescale 1ns/1ps
module rwq_arbiter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cfg_drain_pct = 7'd50;
  logic cfg_frfcfs = 1'b0;
  logic rd_valid = 1'b0, rd_ready, rd_retry;
  logic [11:0] rd_addr = '0;
  logic wr_valid = 1'b0, wr_ready, wr_retry;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic iss_valid, iss_write;
  logic iss_ready = 1'b0;
  logic [11:0] iss_addr;
  logic [15:0] iss_data;
  logic [3:0][5:0] bank_open_row = '0;
  logic [3:0] bank_open_vld = '0;
  logic dram_rd_done = 1'b0;
  logic reads_blocked, resp_valid;
  logic [11:0] resp_addr;
  logic [15:0] resp_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rwq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_drain_pct(cfg_drain_pct), .cfg_frfcfs(cfg_frfcfs),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_retry(rd_retry),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_retry(wr_retry), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_write(iss_write), .iss_addr(iss_addr), .iss_data(iss_data),
    .bank_open_row(bank_open_row), .bank_open_vld(bank_open_vld),
    .dram_rd_done(dram_rd_done), .reads_blocked(reads_blocked),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data)
  );

  // {row, bank, column} layout from R11
  function automatic logic [11:0] mk(input int row, input int bank, input int col);
    return {row[5:0], bank[1:0], col[3:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset(input int pct);
    @(negedge clk);
    rst_n = 1'b0; rd_valid = 1'b0; wr_valid = 1'b0; iss_ready = 1'b0;
    dram_rd_done = 1'b0; cfg_drain_pct = pct[6:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic push_rd(input logic [11:0] a, output bit acc);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    #1 acc = rd_ready;
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
  endtask

  task automatic push_wr(input logic [11:0] a, input logic [15:0] d, output bit acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1 acc = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  // Reset state, picking order, read slot accounting and read retry
  task automatic t_pick_and_slots();
    bit acc;
    do_reset(50);
    chk("R1 reset rd_ready", int'(rd_ready), 1);
    chk("R2 reset wr_ready", int'(wr_ready), 1);
    chk("R6 reset reads_blocked", int'(reads_blocked), 0);
    chk("R3 reset retry flags", int'({rd_retry, wr_retry}), 0);
    chk("R4 reset resp_valid", int'(resp_valid), 0);
    bank_open_row[0] = 6'd2; bank_open_vld = 4'b0001; cfg_frfcfs = 1'b1;
    push_rd(mk(1, 0, 0), acc);
    push_rd(mk(2, 0, 1), acc);
    push_rd(mk(3, 1, 2), acc);
    chk("R11 open-row read chosen", int'(iss_addr), int'(mk(2, 0, 1)));
    cfg_frfcfs = 1'b0; #1;
    chk("R10 oldest read chosen", int'(iss_addr), int'(mk(1, 0, 0)));
    cfg_frfcfs = 1'b1; bank_open_vld = 4'b0000; #1;
    chk("R11 no hit falls back to oldest", int'(iss_addr), int'(mk(1, 0, 0)));
    bank_open_vld = 4'b0001;
    push_rd(mk(4, 2, 3), acc);
    chk("R1 fourth read accepted", int'(acc), 1);
    chk("R1 full read side refuses", int'(rd_ready), 0);
    push_rd(mk(5, 2, 3), acc);
    chk("R1 read refused when full", int'(acc), 0);
    chk("R3 rd_retry after refusal", int'(rd_retry), 1);
    cfg_frfcfs = 1'b0;
    @(negedge clk); iss_ready = 1'b1; #1;
    chk("R10 issued read is oldest", int'(iss_addr), int'(mk(1, 0, 0)));
    @(negedge clk); iss_ready = 1'b0; #1;
    chk("R1 outstanding read holds slot", int'(rd_ready), 0);
    @(negedge clk); dram_rd_done = 1'b1;
    @(negedge clk); dram_rd_done = 1'b0; #1;
    chk("R1 return frees slot", int'(rd_ready), 1);
    push_rd(mk(5, 2, 3), acc);
    chk("R3 rd_retry clears on accept", int'(rd_retry), 0);
  endtask

  // Threshold drain, turnaround gap, write order and resume
  task automatic t_drain_turn();
    bit acc;
    int n;
    do_reset(50);
    push_rd(mk(5, 1, 0), acc);
    push_wr(mk(7, 2, 0), 16'h1111, acc);
    @(negedge clk); #1;
    chk("R5 below level no drain", int'(reads_blocked), 0);
    push_wr(mk(7, 2, 1), 16'h2222, acc);
    chk("R6 flag not yet set", int'(reads_blocked), 0);
    @(negedge clk); #1;
    chk("R5 level reached starts drain", int'(reads_blocked), 1);
    iss_ready = 1'b1;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (iss_valid) break;
      if (reads_blocked) n++;
      @(negedge clk); #1;
    end
    chk("R7 turnaround cycles", n, 3);
    chk("R7 first issue is write", int'(iss_write), 1);
    chk("R7 oldest write first", int'(iss_addr), int'(mk(7, 2, 0)));
    chk("R7 write data", int'(iss_data), 16'h1111);
    @(negedge clk); #1;
    chk("R7 second write", int'(iss_addr), int'(mk(7, 2, 1)));
    for (int k = 0; k < 10; k++) begin
      if (!reads_blocked) break;
      @(negedge clk); #1;
    end
    chk("R8 drain ended", int'(reads_blocked), 0);
    chk("R8 read resumes", int'(iss_valid && !iss_write && iss_addr == mk(5, 1, 0)), 1);
    iss_ready = 1'b0;
  endtask

  // Minimum drain level of one
  task automatic t_min_level();
    bit acc;
    do_reset(10);
    push_rd(mk(1, 1, 1), acc);
    push_wr(mk(2, 2, 2), 16'h0042, acc);
    @(negedge clk); #1;
    chk("R5 level clamped to one", int'(reads_blocked), 1);
  endtask

  // Forwarding and idle drain
  task automatic t_forward();
    bit acc;
    int bad, wn;
    do_reset(50);
    push_wr(mk(9, 3, 4), 16'hAAAA, acc);
    @(negedge clk); #1;
    chk("R9 idle drain starts", int'(reads_blocked), 1);
    push_wr(mk(9, 3, 4), 16'hBBBB, acc);
    push_rd(mk(9, 3, 4), acc);
    chk("R4 forwarded read accepted", int'(acc), 1);
    chk("R4 resp_valid", int'(resp_valid), 1);
    chk("R4 youngest data", int'(resp_data), 16'hBBBB);
    chk("R4 resp_addr", int'(resp_addr), int'(mk(9, 3, 4)));
    @(negedge clk); #1;
    chk("R4 single response", int'(resp_valid), 0);
    iss_ready = 1'b1;
    bad = 0; wn = 0;
    for (int k = 0; k < 30; k++) begin
      if (!reads_blocked) break;
      if (iss_valid && !iss_write) bad++;
      if (iss_valid && iss_write) wn++;
      @(negedge clk); #1;
    end
    chk("R4 no read sent during drain", bad, 0);
    chk("R8 both writes drained", wn, 2);
    @(negedge clk); #1;
    chk("R4 forwarded read never issued", int'(iss_valid), 0);
    iss_ready = 1'b0;
  endtask

  // Write capacity and write retry
  task automatic t_write_full();
    bit acc;
    int na;
    do_reset(50);
    na = 0;
    for (int k = 0; k < 4; k++) begin
      push_wr(mk(k, 1, k), 16'(k), acc);
      na += int'(acc);
    end
    chk("R2 four writes accepted", na, 4);
    chk("R2 full write queue refuses", int'(wr_ready), 0);
    push_wr(mk(20, 1, 0), 16'h0055, acc);
    chk("R2 write refused when full", int'(acc), 0);
    chk("R3 wr_retry after refusal", int'(wr_retry), 1);
    iss_ready = 1'b1;
    for (int k = 0; k < 20; k++) begin
      if (wr_ready) break;
      @(negedge clk); #1;
    end
    iss_ready = 1'b0; #1;
    chk("R2 room after issue", int'(wr_ready), 1);
    push_wr(mk(20, 1, 0), 16'h0055, acc);
    chk("R3 wr_retry clears on accept", int'(wr_retry), 0);
  endtask

  initial begin
    t_pick_and_slots();
    t_drain_turn();
    t_min_level();
    t_forward();
    t_write_full();
    report();
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

endmodule